// File: doc/BRIEF.md
# Drop Bus Position Decoder

This block watches a byte-parallel telecom drop bus and turns its timing leads into position strobes for downstream tributary logic. The bus carries a byte clock, an 8-bit data byte, one shared marker lead and a payload-envelope level. The marker lead can carry three kinds of pulse: the frame-start overhead byte (C1), the start of the path overhead (J1), and the tributary multiframe marker (V1). The block uses the envelope level and the distance from the last J1 to tell these pulses apart. It then places the tributary pointer byte for three bus formats: a single-stream STS-1 bus, a single-container STM-1 bus, and an STS-3 bus that carries three interleaved STS-1s.

The block runs on a free-running reference clock. The byte clock is synchronised into that domain, and each of its rising edges opens one byte slot. Parity is checked on every byte. A missing byte clock raises a loss-of-clock level. A V1 pulse in the wrong frame, or one that is absent from the frame that should carry it, latches a multiframe error. Downstream logic acknowledges that error with a pulse.

Top module: `drop_pos_decoder`

## Requirements
- R1: A byte with the marker high and the envelope low gives exactly one `c1Pulse` in that byte slot. No J1 or V1 strobe is given for that byte.
- R2: A byte with the marker and the envelope both high, that is not at the V1 slot of an earlier J1, gives one `j1Pulse`.
- R3: With `busFmt`=0 (STS-1), a marker with the envelope high on the byte directly after a J1 is a V1 pulse. It raises `v1Pulse` and `v1Byte` in the same byte slot.
- R4: With `busFmt`=1 (single-container STM-1), a marker with the envelope high three bytes after the J1 raises `v1Pulse`. `v1Byte` follows six byte slots after that pulse.
- R5: With `busFmt`=2 (STS-3), up to three J1 pulses per frame are accepted. A marker three bytes after each J1 raises `v1Pulse` and `v1Byte` together.
- R6: With `parEven`=0 and `parDataOnly`=0, the eight data bits, the marker, the envelope and `busPar` must hold an odd number of ones. Each byte that fails raises `parErr` for one reference cycle.
- R7: `parEven`=1 makes the check expect an even count. `parDataOnly`=1 leaves the marker and the envelope out of the count. The two controls combine freely.
- R8: After the first V1 pulse, the block expects a V1 pulse in the frame four C1 pulses later. A frame is counted at each C1. Two cases latch `mfErr` high: a V1 pulse in any other frame, and a V1 slot with no marker in the expected frame. A one-cycle `mfAck` clears the latch. The latch stays high without `mfAck`.
- R9: `clkLoss` rises when no byte-clock rising edge has been seen for `LOC_LIMIT` reference cycles (default 64). It stays high until the next byte slot, which clears it.
- R10: After reset, every strobe, `mfErr` and `clkLoss` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| busClk | input | 1 | Drop bus byte clock; bus leads are taken at its rising edge |
| busData | input | 8 | Drop bus data byte |
| busMarker | input | 1 | Shared C1/J1/V1 marker lead |
| busSpe | input | 1 | Payload-envelope level |
| busPar | input | 1 | Bus parity lead |
| busFmt | input | 2 | Bus format: 0 STS-1, 1 single-container STM-1, 2 STS-3 |
| parEven | input | 1 | 1 selects an even-parity check |
| parDataOnly | input | 1 | 1 limits parity to the data byte |
| mfAck | input | 1 | Clears the latched multiframe error |
| c1Pulse | output | 1 | C1 byte strobe |
| j1Pulse | output | 1 | J1 byte strobe |
| v1Pulse | output | 1 | V1 marker pulse strobe |
| v1Byte | output | 1 | Tributary pointer byte strobe |
| parErr | output | 1 | Parity failure strobe for one byte |
| mfErr | output | 1 | Latched multiframe error |
| clkLoss | output | 1 | Byte clock missing |

## Verification
Each format is driven with multiframes of 14-byte frames. The sequence is: a regular V1 every fourth frame, then a V1 two frames early, then a frame whose V1 is missing, then a return to the regular spacing. These patterns separate a correct decoder from one with the wrong J1-to-V1 gap, the wrong pointer-byte lag, a bad frame count, or a missing error latch. In the STS-3 runs, three back-to-back J1s test whether each slot is tracked on its own. The bench corrupts parity on chosen bytes under all four parity settings. It uses bytes with the envelope high, so a check that drops the marker and envelope leads, or keeps them in data-only mode, shows up. A stalled byte clock tests that loss of clock is declared and then cleared by the next byte.

// File: rtl/drop_pos_pkg.sv
package drop_pos_pkg;

  typedef enum logic [1:0] {
    FMT_STS1 = 2'd0,
    FMT_VC4  = 2'd1,
    FMT_STS3 = 2'd2
  } busFmt_e;

  // datapath -> control: one byte slot worth of timing leads
  typedef struct packed {
    logic byteEn;
    logic marker;
    logic spe;
  } laneStrb_t;

  // control -> top: registered position strobes
  typedef struct packed {
    logic c1;
    logic j1;
    logic v1Pulse;
    logic v1Byte;
  } posEvt_t;

endpackage

// File: rtl/drop_pos_datapath.sv
module drop_pos_datapath
  import drop_pos_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LOC_LIMIT   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busClk,
  input  logic [DATA_W-1:0] busData,
  input  logic              busMarker,
  input  logic              busSpe,
  input  logic              busPar,
  input  logic              parEven,
  input  logic              parDataOnly,
  output laneStrb_t         lanes,
  output logic              parErr,
  output logic              clkLoss
);

  localparam int LANE_W = DATA_W + 3;
  localparam int GAP_W  = $clog2(LOC_LIMIT + 1);

  logic [SYNC_STAGES:0] clkSync;
  logic [LANE_W-1:0]    lanePipe [SYNC_STAGES];
  logic [LANE_W-1:0]    laneWord;
  logic                 byteEn;
  logic [DATA_W-1:0]    capData;
  logic                 capMarker;
  logic                 capSpe;
  logic                 capPar;
  logic                 onesOdd;
  logic                 parBad;
  logic [GAP_W-1:0]     gapCnt;

  // byte clock synchroniser with one extra stage for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) clkSync <= '0;
    else       clkSync <= {clkSync[SYNC_STAGES-1:0], busClk};
  end

  // bus leads travel through the same number of stages as the clock
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) lanePipe[i] <= '0;
    end else begin
      lanePipe[0] <= {busData, busMarker, busSpe, busPar};
      for (int i = 1; i < SYNC_STAGES; i++) lanePipe[i] <= lanePipe[i-1];
    end
  end

  assign byteEn    = clkSync[SYNC_STAGES-1] & ~clkSync[SYNC_STAGES];
  assign laneWord  = lanePipe[SYNC_STAGES-1];
  assign capData   = laneWord[LANE_W-1:3];
  assign capMarker = laneWord[2];
  assign capSpe    = laneWord[1];
  assign capPar    = laneWord[0];

  assign lanes.byteEn = byteEn;
  assign lanes.marker = capMarker;
  assign lanes.spe    = capSpe;

  // parity: lead coverage picked by control bit, sense by another
  generate
    if (DATA_W > 0) begin : gParity
      always_comb begin
        if (parDataOnly) onesOdd = ^{capData, capPar};
        else             onesOdd = ^{capData, capMarker, capSpe, capPar};
        parBad = parEven ? onesOdd : ~onesOdd;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) parErr <= 1'b0;
    else       parErr <= byteEn & parBad;
  end

  // loss of byte clock watchdog on the reference clock
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt  <= '0;
      clkLoss <= 1'b0;
    end else if (byteEn) begin
      gapCnt  <= '0;
      clkLoss <= 1'b0;
    end else begin
      if (gapCnt != GAP_W'(LOC_LIMIT)) gapCnt <= gapCnt + 1'b1;
      if (gapCnt == GAP_W'(LOC_LIMIT - 1)) clkLoss <= 1'b1;
    end
  end

  AST_PAR_ON_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    parErr |-> $past(byteEn)); // R6
  AST_LOC_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    byteEn |=> !clkLoss); // R9
  AST_LOC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (clkLoss && !byteEn) |=> clkLoss); // R9

endmodule

// File: rtl/drop_pos_control.sv
module drop_pos_control
  import drop_pos_pkg::*;
#(
  parameter int STS1_V1_GAP  = 1,
  parameter int VC4_V1_GAP   = 3,
  parameter int STS3_V1_GAP  = 3,
  parameter int VC4_BYTE_LAG = 6
) (
  input  logic      clk,
  input  logic      rstN,
  input  busFmt_e   fmt,
  input  laneStrb_t lanes,
  input  logic      mfAck,
  output posEvt_t   evt,
  output logic      mfErr
);

  localparam int GAP_A   = (STS1_V1_GAP > VC4_V1_GAP) ? STS1_V1_GAP : VC4_V1_GAP;
  localparam int GAP_MAX = (GAP_A > STS3_V1_GAP) ? GAP_A : STS3_V1_GAP;

  logic [GAP_MAX:1] j1Hist;
  logic             v1Slot;
  logic             isC1;
  logic             isJ1;
  logic             isV1;
  logic             slotMiss;
  logic             lagTap;
  logic             v1ByteNow;
  logic [1:0]       fPhase;
  logic             locked;
  logic             mfHit;

  // V1 slot: the byte a format-specific distance after a J1
  always_comb begin
    case (fmt)
      FMT_VC4:  v1Slot = j1Hist[VC4_V1_GAP];
      FMT_STS3: v1Slot = j1Hist[STS3_V1_GAP];
      default:  v1Slot = j1Hist[STS1_V1_GAP];
    endcase
  end

  assign isC1     = lanes.marker & ~lanes.spe;
  assign isV1     = lanes.marker & lanes.spe & v1Slot;
  assign isJ1     = lanes.marker & lanes.spe & ~v1Slot;
  assign slotMiss = v1Slot & ~(lanes.marker & lanes.spe);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      j1Hist <= '0;
    end else if (lanes.byteEn) begin
      j1Hist[1] <= isJ1;
      for (int k = 2; k <= GAP_MAX; k++) j1Hist[k] <= j1Hist[k-1];
    end
  end

  // pointer byte lag behind the V1 pulse (single-container format)
  generate
    if (VC4_BYTE_LAG == 0) begin : gLagNone
      assign lagTap = isV1;
    end else begin : gLagLine
      logic [VC4_BYTE_LAG:1] lagHist;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          lagHist <= '0;
        end else if (lanes.byteEn) begin
          lagHist[1] <= isV1;
          for (int k = 2; k <= VC4_BYTE_LAG; k++) lagHist[k] <= lagHist[k-1];
        end
      end
      assign lagTap = lagHist[VC4_BYTE_LAG];
    end
  endgenerate

  assign v1ByteNow = (fmt == FMT_VC4) ? lagTap : isV1;

  // multiframe tracking: frames counted on C1, V1 due at phase 0
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fPhase <= '0;
      locked <= 1'b0;
    end else if (lanes.byteEn) begin
      if (isV1) begin
        fPhase <= '0;
        locked <= 1'b1;
      end else if (isC1) begin
        fPhase <= fPhase + 2'd1;
      end
    end
  end

  assign mfHit = lanes.byteEn & locked &
                 ((isV1 & (fPhase != 2'd0)) | (slotMiss & (fPhase == 2'd0)));

  always_ff @(posedge clk) begin
    if (!rstN)      mfErr <= 1'b0;
    else if (mfHit) mfErr <= 1'b1;
    else if (mfAck) mfErr <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evt <= '0;
    end else begin
      evt.c1      <= lanes.byteEn & isC1;
      evt.j1      <= lanes.byteEn & isJ1;
      evt.v1Pulse <= lanes.byteEn & isV1;
      evt.v1Byte  <= lanes.byteEn & v1ByteNow;
    end
  end

  AST_C1_ON_LOW_SPE: assert property (@(posedge clk) disable iff (!rstN)
    (lanes.byteEn && lanes.marker && !lanes.spe) |=> (evt.c1 && !evt.j1 && !evt.v1Pulse)); // R1
  AST_HIGH_SPE_NOT_C1: assert property (@(posedge clk) disable iff (!rstN)
    (lanes.byteEn && lanes.marker && lanes.spe) |=> (!evt.c1 && (evt.j1 || evt.v1Pulse))); // R2
  AST_STS1_SAME_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (fmt == FMT_STS1 && evt.v1Pulse) |-> evt.v1Byte); // R3
  AST_STS3_SAME_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (fmt == FMT_STS3 && evt.v1Pulse) |-> evt.v1Byte); // R5
  AST_MF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (mfErr && !mfAck) |=> mfErr); // R8
  AST_MF_ON_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mfErr) |-> $past(lanes.byteEn)); // R8

endmodule

// File: rtl/drop_pos_decoder.sv
module drop_pos_decoder
  import drop_pos_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int LOC_LIMIT    = 64,
  parameter int STS1_V1_GAP  = 1,
  parameter int VC4_V1_GAP   = 3,
  parameter int STS3_V1_GAP  = 3,
  parameter int VC4_BYTE_LAG = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busClk,
  input  logic [DATA_W-1:0] busData,
  input  logic              busMarker,
  input  logic              busSpe,
  input  logic              busPar,
  input  logic [1:0]        busFmt,
  input  logic              parEven,
  input  logic              parDataOnly,
  input  logic              mfAck,
  output logic              c1Pulse,
  output logic              j1Pulse,
  output logic              v1Pulse,
  output logic              v1Byte,
  output logic              parErr,
  output logic              mfErr,
  output logic              clkLoss
);

  laneStrb_t lanes;
  posEvt_t   evt;

  drop_pos_datapath #(
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES),
    .LOC_LIMIT   (LOC_LIMIT)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .busClk      (busClk),
    .busData     (busData),
    .busMarker   (busMarker),
    .busSpe      (busSpe),
    .busPar      (busPar),
    .parEven     (parEven),
    .parDataOnly (parDataOnly),
    .lanes       (lanes),
    .parErr      (parErr),
    .clkLoss     (clkLoss)
  );

  drop_pos_control #(
    .STS1_V1_GAP  (STS1_V1_GAP),
    .VC4_V1_GAP   (VC4_V1_GAP),
    .STS3_V1_GAP  (STS3_V1_GAP),
    .VC4_BYTE_LAG (VC4_BYTE_LAG)
  ) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .fmt   (busFmt_e'(busFmt)),
    .lanes (lanes),
    .mfAck (mfAck),
    .evt   (evt),
    .mfErr (mfErr)
  );

  assign c1Pulse = evt.c1;
  assign j1Pulse = evt.j1;
  assign v1Pulse = evt.v1Pulse;
  assign v1Byte  = evt.v1Byte;

endmodule

// File: tb/tb_drop_pos_decoder.sv
`timescale 1ns/1ps
module tb_drop_pos_decoder;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busClk = 1'b0;
  logic [7:0] busData = '0;
  logic       busMarker = 1'b0;
  logic       busSpe = 1'b0;
  logic       busPar = 1'b0;
  logic [1:0] busFmt = 2'd0;
  logic       parEven = 1'b0;
  logic       parDataOnly = 1'b0;
  logic       mfAck = 1'b0;
  logic       c1Pulse, j1Pulse, v1Pulse, v1Byte, parErr, mfErr, clkLoss;

  always #4 clk = ~clk;

  drop_pos_decoder dut (
    .clk(clk), .rstN(rstN), .busClk(busClk), .busData(busData),
    .busMarker(busMarker), .busSpe(busSpe), .busPar(busPar), .busFmt(busFmt),
    .parEven(parEven), .parDataOnly(parDataOnly), .mfAck(mfAck),
    .c1Pulse(c1Pulse), .j1Pulse(j1Pulse), .v1Pulse(v1Pulse), .v1Byte(v1Byte),
    .parErr(parErr), .mfErr(mfErr), .clkLoss(clkLoss)
  );

  int checks = 0;
  int errors = 0;
  int byteNo = 0;
  int frameNo = 0;
  bit done = 0;
  bit prevMf = 0;
  int expQ[$];   // entries: byteNo*8 + kind (0 C1,1 J1,2 V1P,3 V1B,4 PAR,5 MF)

  function automatic string reqOf(input int kind);
    case (kind)
      0: return "R1";
      1: return "R2";
      2, 3: return (busFmt == 2'd1) ? "R4" : (busFmt == 2'd2) ? "R5" : "R3";
      4: return (parEven || parDataOnly) ? "R7" : "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic checkVal(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pop the scoreboard as the design raises events
  task automatic popCheck(input int kind);
    int got;
    got = byteNo * 8 + kind;
    checks++;
    if (expQ.size() == 0) begin
      errors++;
      $display("FAIL %s unexpected event actual=byte%0d/kind%0d expected=none",
               reqOf(kind), byteNo, kind);
    end else begin
      int want;
      want = expQ.pop_front();
      if (want != got) begin
        errors++;
        $display("FAIL %s event mismatch actual=byte%0d/kind%0d expected=byte%0d/kind%0d",
                 reqOf(want % 8), byteNo, kind, want / 8, want % 8);
      end
    end
  endtask

  always @(negedge clk) begin
    if (!rstN) begin
      prevMf = 0;
    end else begin
      if (c1Pulse) popCheck(0);
      if (j1Pulse) popCheck(1);
      if (v1Pulse) popCheck(2);
      if (v1Byte)  popCheck(3);
      if (parErr)  popCheck(4);
      if (mfErr && !prevMf) popCheck(5);
      prevMf = mfErr;
    end
  end

  function automatic logic parFor(input logic mk, input logic spe, input logic [7:0] d, input bit bad);
    logic s;
    s = parDataOnly ? ^d : ^{d, mk, spe};
    return (parEven ? 1'b0 : 1'b1) ^ s ^ logic'(bad);
  endfunction

  // driver: one byte slot of 7 reference cycles, rising byte clock mid-slot
  task automatic sendByte(input logic mk, input logic spe, input logic [7:0] d,
                          input logic [5:0] expMask, input bit badPar);
    logic [5:0] m;
    @(negedge clk);
    byteNo++;
    m = expMask;
    m[4] = badPar;
    for (int k = 0; k < 6; k++) if (m[k]) expQ.push_back(byteNo * 8 + k);
    busClk = 1'b0;
    busData = d;
    busMarker = mk;
    busSpe = spe;
    busPar = parFor(mk, spe, d, badPar);
    repeat (2) @(negedge clk);
    busClk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // 14-byte frame: C1 at 0, J1(s) from 3, V1(s) after the format gap
  task automatic sendFrame(input bit hasV1, input bit expMf, input int badAt);
    int gap, lag, nJ;
    gap = (busFmt == 2'd0) ? 1 : 3;
    lag = (busFmt == 2'd1) ? 6 : 0;
    nJ  = (busFmt == 2'd2) ? 3 : 1;
    frameNo++;
    for (int p = 0; p < 14; p++) begin
      bit isJ, isV, isVB;
      logic [5:0] m;
      isJ  = (p >= 3) && (p < 3 + nJ);
      isV  = hasV1 && (p >= 3 + gap) && (p < 3 + gap + nJ);
      isVB = hasV1 && (p >= 3 + gap + lag) && (p < 3 + gap + lag + nJ);
      m = '0;
      m[0] = (p == 0);
      m[1] = isJ;
      m[2] = isV;
      m[3] = isVB;
      m[5] = expMf && (p == 3 + gap);
      sendByte((p == 0) || isJ || isV, p != 0, 8'(p * 37 + frameNo * 11), m, p == badAt);
    end
  endtask

  task automatic doReset(input logic [1:0] fmt);
    @(negedge clk);
    rstN = 1'b0;
    busClk = 1'b0;
    busMarker = 1'b0;
    busFmt = fmt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic ackMf(input string req);
    checkVal(req, "mfErr latched before ack", int'(mfErr), 1);
    @(negedge clk) mfAck = 1'b1;
    @(negedge clk) mfAck = 1'b0;
    @(negedge clk);
    checkVal(req, "mfErr after ack", int'(mfErr), 0);
  endtask

  // multiframe run: regular, early V1, missing V1, regular again
  task automatic runFormat(input logic [1:0] fmt, input int badFrame, input int badAt);
    doReset(fmt);
    for (int f = 0; f < 15; f++) begin
      bit v1, err;
      v1  = (f == 0) || (f == 4) || (f == 6) || (f == 14);
      err = (f == 6) || (f == 10);
      sendFrame(v1, err, (f == badFrame) ? badAt : -1);
      if (err) ackMf("R8");
    end
    checkVal("R8", "mfErr quiet on regular spacing", int'(mfErr), 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R10: reset state
    checkVal("R10", "strobes in reset",
             int'({c1Pulse, j1Pulse, v1Pulse, v1Byte, parErr, mfErr, clkLoss}), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R10", "outputs after reset",
             int'({c1Pulse, j1Pulse, v1Pulse, v1Byte, parErr, mfErr, clkLoss}), 0);

    runFormat(2'd0, 2, 5);    // R3 with an R6 parity slip mid-frame
    runFormat(2'd1, 3, 0);    // R4, parity slip on the C1 byte
    runFormat(2'd2, 12, 4);   // R5, parity slip on the second J1

    // R6/R7 parity modes with envelope-high and envelope-low fillers
    for (int mode = 0; mode < 4; mode++) begin
      @(negedge clk);
      parEven = mode[0];
      parDataOnly = mode[1];
      for (int k = 0; k < 6; k++)
        sendByte(1'b0, k[0], 8'(k * 53 + mode * 7 + 1), 6'd0, (k == 1) || (k == 4));
    end
    parEven = 1'b0;
    parDataOnly = 1'b0;

    // R9: byte clock stall and recovery
    sendByte(1'b0, 1'b1, 8'h5a, 6'd0, 1'b0);
    checkVal("R9", "clkLoss while bytes flow", int'(clkLoss), 0);
    @(negedge clk) busClk = 1'b0;
    repeat (100) @(negedge clk);
    checkVal("R9", "clkLoss after stall", int'(clkLoss), 1);
    sendByte(1'b0, 1'b1, 8'h3c, 6'd0, 1'b0);
    checkVal("R9", "clkLoss after recovery", int'(clkLoss), 0);

    repeat (10) @(negedge clk);
    checkVal("R1", "scoreboard drained", expQ.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule